// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block raises periodic auto-refresh requests toward a DRAM command sequencer. One 32-bit configuration word controls it. The word carries four fields:

- an off switch;
- the number of refreshes in one burst;
- the interval between bursts;
- the minimum recovery time a refresh needs before the next command.

When the interval runs out, the block issues a burst of refresh requests. Each request is a request/grant handshake with the sequencer. A busy flag tells the memory arbiter to keep other traffic away. It stays high from the first request of a burst until the recovery time after the last refresh has elapsed.

Refreshes are deliberately postponed and then sent in bursts of one to sixteen commands. The interval field therefore covers a whole burst rather than one refresh slot. An interval that ends while a burst is still running is remembered, and the next burst follows as soon as the running one finishes. Precharging the banks, self-refresh and the DRAM pins belong to other blocks.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, and after it until the first interval has elapsed, refreshReq and refreshBusy are low.
- R2: With bit 31 of the word clear, the interval field P (bits 23:8) makes the first request of a burst rise P+1 clocks after reset release or re-enable. Later bursts follow every P+1 clocks whenever a burst is shorter than that.
- R3: A burst holds exactly L+1 requests, where L is bits 27:24, captured when the burst starts.
- R4: refreshReq stays high until refreshGnt is sampled high, and is low in the clock after the grant clock.
- R5: After a grant in clock c, the next request of the same burst rises in clock c+max(T,1)+1. T is bits 7:0, captured at the grant.
- R6: refreshBusy is high whenever refreshReq is high. It rises with the first request of a burst and falls in clock c+max(T,1)+1 after the last grant c.
- R7: With bit 31 set, no burst starts and the interval count is held at zero. After bit 31 is cleared in clock m, the first request rises in clock m+P+1, whatever part of the interval had run before.
- R8: An interval that ends while a burst is busy is remembered, at most one at a time. The next burst then starts one clock after refreshBusy falls.
- R9: Setting bit 31 during a burst lets that burst complete. Any remembered interval is dropped, so no further burst follows.
- R10: With the word 0x086C9883 and immediate grants, a burst of 9 requests spaced 132 clocks apart starts 27801 clocks after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Configuration: off switch, burst length, interval, recovery time |
| refreshReq | output | 1 | Refresh request to the command sequencer |
| refreshGnt | input | 1 | Sequencer accepts the pending refresh in this clock |
| refreshBusy | output | 1 | Refresh burst in progress; arbiter holds off other traffic |

## Verification
The two functions that can land in the same clock are the interval counter running out and a burst still occupying the sequencer. The bench provokes this by programming an interval shorter than the burst, so that an expiry arrives in every burst. It then predicts each start as the later of the expiry and the clock after refreshBusy falls.

A second collision places the off switch in the clock where a remembered interval would start a burst, and another places it in the middle of a burst. In the first case no burst may follow. In the second the running burst must complete, with exactly its request count, and nothing may follow it.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  // controller phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } refStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBurst;  // capture burst length at burst start
    logic decBurst;   // one refresh of the burst consumed
    logic loadGap;    // grant seen: start recovery wait
  } refStrobeT;

endpackage

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int BURST_W  = 4,
  parameter int TRFC_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                periodEnable,
  input  logic [PERIOD_W-1:0] periodVal,
  input  logic [BURST_W-1:0]  burstLenVal,
  input  logic [TRFC_W-1:0]   trfcVal,
  input  refStrobeT           strobe,
  output logic                periodExpire,
  output logic                gapDone,
  output logic                burstLast
);

  localparam logic [TRFC_W-1:0]  GAP_ONE  = TRFC_W'(1);
  localparam logic [BURST_W-1:0] BURST_Z  = '0;

  logic [PERIOD_W-1:0] periodCnt;
  logic [BURST_W-1:0]  burstLeft;
  logic [TRFC_W-1:0]   gapCnt;

  // interval counter: up-count, compare with >= so a shrunk interval still fires
  assign periodExpire = periodEnable && (periodCnt >= periodVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodCnt <= '0;
    end else if (!periodEnable || periodExpire) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  // refreshes still owed in the current burst
  assign burstLast = (burstLeft == BURST_Z);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burstLeft <= '0;
    end else if (strobe.loadBurst) begin
      burstLeft <= burstLenVal;
    end else if (strobe.decBurst) begin
      burstLeft <= burstLeft - 1'b1;
    end
  end

  // recovery wait after each granted refresh
  assign gapDone = (gapCnt <= GAP_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (strobe.loadGap) begin
      gapCnt <= trfcVal;
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  // R3: the burst count is never stepped below zero
  p_burst_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.decBurst |-> (burstLeft != BURST_Z));

  // R7: while switched off the interval never ends
  p_no_expire_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodEnable && $past(!periodEnable)) |-> !periodExpire);

  // R5: a new recovery wait only starts from a finished one
  p_gap_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadGap |-> gapDone);

endmodule

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      periodExpire,
  input  logic      gapDone,
  input  logic      burstLast,
  input  logic      refreshGnt,
  output refStrobeT strobe,
  output logic      refreshReq,
  output logic      refreshBusy
);

  refStateT stateQ, stateD;
  logic     pendingQ;
  logic     startBurst;

  assign startBurst = (stateQ == ST_IDLE) && enable && (periodExpire || pendingQ);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startBurst) begin
          stateD           = ST_REQ;
          strobe.loadBurst = 1'b1;
        end
      end
      ST_REQ: begin
        if (refreshGnt) begin
          stateD         = ST_GAP;
          strobe.loadGap = 1'b1;
        end
      end
      ST_GAP: begin
        if (gapDone) begin
          if (burstLast) begin
            stateD = ST_IDLE;
          end else begin
            stateD          = ST_REQ;
            strobe.decBurst = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  // one remembered interval; dropped when switched off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingQ <= 1'b0;
    end else if (!enable) begin
      pendingQ <= 1'b0;
    end else if (stateQ == ST_IDLE) begin
      pendingQ <= pendingQ && periodExpire;
    end else begin
      pendingQ <= pendingQ || periodExpire;
    end
  end

  assign refreshReq  = (stateQ == ST_REQ);
  assign refreshBusy = (stateQ != ST_IDLE);

  // R4: request held until granted
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshReq && !refreshGnt) |=> refreshReq);

  // R4: request withdrawn right after its grant
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshReq && refreshGnt) |=> !refreshReq);

  // R6: no request outside a busy window
  p_req_inside_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refreshReq |-> refreshBusy);

  // R8: an interval is only remembered while a burst runs
  p_pending_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendingQ) |-> ($past(stateQ) != ST_IDLE));

  // R9: switched off while idle, no burst starts
  p_no_start_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!refreshBusy && !enable) |=> !refreshBusy);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int OFF_POS    = 31,
  parameter int BURST_LSB  = 24,
  parameter int BURST_W    = 4,
  parameter int PERIOD_LSB = 8,
  parameter int PERIOD_W   = 16,
  parameter int TRFC_LSB   = 0,
  parameter int TRFC_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             refreshReq,
  input  logic             refreshGnt,
  output logic             refreshBusy
);

  localparam int BURST_MSB  = BURST_LSB + BURST_W - 1;
  localparam int PERIOD_MSB = PERIOD_LSB + PERIOD_W - 1;
  localparam int TRFC_MSB   = TRFC_LSB + TRFC_W - 1;

  logic                enable;
  logic [PERIOD_W-1:0] periodVal;
  logic [BURST_W-1:0]  burstLenVal;
  logic [TRFC_W-1:0]   trfcVal;
  logic                periodExpire;
  logic                gapDone;
  logic                burstLast;
  logic                unusedCfg;
  refStrobeT           strobe;

  assign enable      = !cfgWord[OFF_POS];
  assign periodVal   = cfgWord[PERIOD_MSB:PERIOD_LSB];
  assign burstLenVal = cfgWord[BURST_MSB:BURST_LSB];
  assign trfcVal     = cfgWord[TRFC_MSB:TRFC_LSB];
  assign unusedCfg   = ^cfgWord;

  refresh_sched_dp #(
    .PERIOD_W(PERIOD_W),
    .BURST_W (BURST_W),
    .TRFC_W  (TRFC_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .periodEnable(enable),
    .periodVal   (periodVal),
    .burstLenVal (burstLenVal),
    .trfcVal     (trfcVal),
    .strobe      (strobe),
    .periodExpire(periodExpire),
    .gapDone     (gapDone),
    .burstLast   (burstLast)
  );

  refresh_sched_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .periodExpire(periodExpire),
    .gapDone     (gapDone),
    .burstLast   (burstLast),
    .refreshGnt  (refreshGnt),
    .strobe      (strobe),
    .refreshReq  (refreshReq),
    .refreshBusy (refreshBusy)
  );

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfgWord;
  logic        refreshGnt;
  logic        refreshReq;
  logic        refreshBusy;

  always #4 clk = ~clk;  // 125 MHz

  refresh_sched uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWord    (cfgWord),
    .refreshReq (refreshReq),
    .refreshGnt (refreshGnt),
    .refreshBusy(refreshBusy)
  );

  typedef struct {
    int    cyc;
    string tag;
  } expT;

  expT reqQ[$];
  expT fallQ[$];
  int  cycNum   = 0;
  int  checks   = 0;
  int  errors   = 0;
  int  gntDelay = 0;
  int  lastGnt  = -100;
  int  riseCnt  = 0;
  bit  finished = 0;

  always @(posedge clk) cycNum <= cycNum + 1;

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] mkCfg(bit off, int len, int per, int trfc);
    return {off, 3'b000, len[3:0], per[15:0], trfc[7:0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cycNum);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // grant responder: grants a request gntDelay clocks after it rises
  initial begin
    int age;
    age = 0;
    refreshGnt = 1'b0;
    forever begin
      @(negedge clk);
      if (refreshReq) begin
        if (age == gntDelay) begin
          refreshGnt = 1'b1;
          lastGnt    = cycNum;
        end else begin
          refreshGnt = 1'b0;
        end
        age++;
      end else begin
        refreshGnt = 1'b0;
        age = 0;
      end
    end
  end

  // monitor: pops expected events and compares their clocks
  initial begin
    bit prevReq, prevBusy;
    prevReq = 0;
    prevBusy = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (refreshReq && !prevReq) begin
          riseCnt++;
          check(refreshBusy == 1'b1, "R6 busy with request", refreshBusy, 1);
          if (reqQ.size() == 0) begin
            check(0, "R7/R9 unexpected request", cycNum, -1);
          end else begin
            expT e;
            e = reqQ.pop_front();
            check(e.cyc == cycNum, {e.tag, " request rise"}, cycNum, e.cyc);
          end
        end
        if (!refreshReq && prevReq) begin
          check(lastGnt == cycNum - 1, "R4 drop after grant", lastGnt, cycNum - 1);
        end
        if (!refreshBusy && prevBusy) begin
          if (fallQ.size() == 0) begin
            check(0, "R6 unexpected busy fall", cycNum, -1);
          end else begin
            expT e;
            e = fallQ.pop_front();
            check(e.cyc == cycNum, {e.tag, " busy fall"}, cycNum, e.cyc);
          end
        end
      end
      prevReq  = refreshReq;
      prevBusy = refreshBusy;
    end
  end

  // driver: predicts K bursts after an enable in clock m
  task automatic planBursts(int m, int per, int n, int trfc, int g, int k,
                            string tag, output int lastFall);
    int step, prevFall;
    step = g + mx(trfc, 1) + 1;
    prevFall = -1000000;
    for (int b = 0; b < k; b++) begin
      int expiry, st;
      expiry = m + per + b * (per + 1);
      st = mx(expiry + 1, prevFall + 1);
      for (int j = 0; j < n; j++) begin
        expT e;
        e.cyc = st + j * step;
        e.tag = tag;
        reqQ.push_back(e);
      end
      prevFall = st + n * step;
      begin
        expT f;
        f.cyc = prevFall;
        f.tag = tag;
        fallQ.push_back(f);
      end
    end
    lastFall = prevFall;
  endtask

  task automatic waitCycle(int target);
    while (cycNum < target) @(negedge clk);
  endtask

  task automatic offAndDrain(int lastFall, string tag);
    waitCycle(lastFall);
    cfgWord[31] = 1'b1;
    repeat (20) @(negedge clk);
    check(reqQ.size() == 0, {tag, " requests outstanding"}, reqQ.size(), 0);
    check(fallQ.size() == 0, {tag, " busy falls outstanding"}, fallQ.size(), 0);
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycNum);
    summary();
  end

  initial begin
    int m, lf, r0;
    rst_n = 1'b0;
    cfgWord = 32'h086C_9883;
    repeat (3) @(negedge clk);
    check(refreshReq == 1'b0, "R1 req in reset", refreshReq, 0);
    check(refreshBusy == 1'b0, "R1 busy in reset", refreshBusy, 0);

    // R10 / R1: reset word, immediate grants
    rst_n = 1'b1;
    m = cycNum;
    gntDelay = 0;
    planBursts(m, 16'h6C98, 9, 8'h83, 0, 1, "R10", lf);
    repeat (5) @(negedge clk);
    check(refreshBusy == 1'b0, "R1 busy after reset", refreshBusy, 0);
    offAndDrain(lf, "R10");

    // R2 / R3: regular bursts, delayed grants
    @(negedge clk);
    gntDelay = 2;
    cfgWord = mkCfg(0, 2, 200, 5);
    m = cycNum;
    planBursts(m, 200, 3, 5, 2, 3, "R2/R3", lf);
    offAndDrain(lf, "R2/R3");

    // R5: zero recovery time still leaves one idle clock
    @(negedge clk);
    gntDelay = 0;
    cfgWord = mkCfg(0, 3, 40, 0);
    m = cycNum;
    planBursts(m, 40, 4, 0, 0, 3, "R5", lf);
    offAndDrain(lf, "R5");

    // R8 / R9: interval shorter than a burst; switched off when a deferred burst is due
    @(negedge clk);
    gntDelay = 1;
    cfgWord = mkCfg(0, 1, 20, 10);
    m = cycNum;
    planBursts(m, 20, 2, 10, 1, 3, "R8", lf);
    offAndDrain(lf, "R8");
    r0 = riseCnt;
    repeat (80) @(negedge clk);
    check(riseCnt == r0, "R9 no deferred burst after off", riseCnt, r0);

    // R7: off window, then restart mid-interval
    cfgWord = mkCfg(1, 0, 5, 2);
    r0 = riseCnt;
    repeat (200) @(negedge clk);
    check(riseCnt == r0, "R7 quiet while off", riseCnt, r0);
    gntDelay = 0;
    cfgWord = mkCfg(0, 0, 50, 2);
    repeat (30) @(negedge clk);
    cfgWord[31] = 1'b1;
    repeat (5) @(negedge clk);
    cfgWord[31] = 1'b0;
    m = cycNum;
    planBursts(m, 50, 1, 2, 0, 1, "R7", lf);
    offAndDrain(lf, "R7");

    // R9: switched off in the middle of a burst with an interval remembered
    @(negedge clk);
    gntDelay = 0;
    cfgWord = mkCfg(0, 3, 10, 3);
    m = cycNum;
    r0 = riseCnt;
    planBursts(m, 10, 4, 3, 0, 1, "R9", lf);
    waitCycle(m + 25);
    cfgWord[31] = 1'b1;
    waitCycle(lf + 60);
    check(riseCnt - r0 == 4, "R9 burst completes then stops", riseCnt - r0, 4);
    check(reqQ.size() == 0, "R9 requests outstanding", reqQ.size(), 0);
    check(fallQ.size() == 0, "R9 busy falls outstanding", fallQ.size(), 0);
    check(refreshBusy == 1'b0, "R9 idle at end", refreshBusy, 0);

    summary();
  end

endmodule